// File: doc/BRIEF.md
# Five-Step Instruction Control Sequencer

This block generates the timing steps and the control enables for a simple multi-cycle RISC datapath. Every instruction passes through the same steps: fetch, decode with register read, ALU work, memory access and register writeback. A step register advances by one step on each clock. Two steps can stall. The fetch step waits until the memory system reports that the access has finished. The memory step waits in the same way, but only for loads and stores. The sequencer also holds the fetched instruction word. It decodes the instruction class from that held word and combines the class with the current step to drive the PC update, the instruction-register load, the register-file write and the memory read and write requests.

An instruction ends at its last useful step, and the sequencer then starts the next fetch. Loads, ALU operations and calls use all five steps. Stores end after the memory step. Every kind of branch, jump or return ends after the ALU step, because the PC is updated there. The held instruction word is driven out so that the datapath can take its register and immediate fields from it.

Top module: `ctl_step_seq`

## Requirements
- R1: Outside the stall conditions, the step advances one step per clock, from T1 through T5. `step_oh` is one-hot, with bit 0 for T1 up to bit 4 for T5.
- R2: T1 (fetch) is the same for every instruction. It asserts `mem_rd` and stays in T1 until `mfc` is sampled high, then moves to T2.
- R3: T4 stays in place while `mfc` is low only when the held instruction is a load or a store. In every other step and class, `mfc` has no effect on the step sequence.
- R4: The opcode is bits [5:0] of the held word, with these codes: 0 ALU, 1 load, 2 store, 3 branch, 4 conditional branch, 5 call, 6 return, 7 jump. Every other code is a no-op. Branch, conditional branch, return, jump and no-op return to T1 after T3. Store returns after T4. ALU, load and call return after T5.
- R5: `mem_rd` is high in T1 and in T4 of a load. `mem_wr` is high only in T4 of a store. A request drops in the cycle after `mfc` is sampled high, unless that edge starts a new fetch.
- R6: `ir_en` pulses in T1 in the cycle where `mfc` is high, and `ir_hold` takes `instr_in` at that edge. `ir_hold` then stays unchanged whatever `instr_in` does until the next fetch completes.
- R7: `pc_en` is high in T1 when `mfc` is high, and in T3 when a branch is taken. A branch is taken for branch, call, return and jump always, and for a conditional branch when `cond_true` is high.
- R8: `rf_we` is high only in T5, which only ALU, load and call instructions reach.
- R9: While `rst_n` is low (asynchronous, active low), the step is T1 and every request and enable is low. In the first clock after release, no request is made. The fetch starts on the following clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| mfc | input | 1 | Memory access completed in this cycle |
| cond_true | input | 1 | Branch condition result from the datapath comparator |
| instr_in | input | IW | Instruction word returned by memory during fetch |
| step_oh | output | 5 | One-hot current step, bit 0 = T1 |
| ir_hold | output | IW | Held instruction word |
| ir_en | output | 1 | Instruction register load enable |
| pc_en | output | 1 | Program counter update enable |
| rf_we | output | 1 | Register file write enable |
| mem_rd | output | 1 | Memory read request |
| mem_wr | output | 1 | Memory write request |

## Verification
The bench feeds a stream of instructions through a memory responder. First come directed opcodes covering every class and the no-op codes, then pseudo-random ones. The responder's completion latency varies from zero to several cycles. The latency variation separates a sequencer that truly waits on `mfc` from one that counts a fixed number of cycles. The class mix separates the three possible end steps. Stray `mfc` pulses in non-waiting steps, random `cond_true` values and a noisy `instr_in` between fetches show that those inputs matter only where R3, R6 and R7 allow. A reset in the middle of the run checks the quiet first cycle of R9.

// File: rtl/ctl_step_pkg.sv
package ctl_step_pkg;

  localparam int NUM_STEPS = 5;

  typedef enum logic [2:0] {
    ST_FETCH  = 3'd0,
    ST_DECODE = 3'd1,
    ST_EXEC   = 3'd2,
    ST_MEM    = 3'd3,
    ST_WBACK  = 3'd4
  } step_e;

  // Opcode values (low field of the held instruction word)
  localparam int OP_ALU    = 0;
  localparam int OP_LOAD   = 1;
  localparam int OP_STORE  = 2;
  localparam int OP_BRANCH = 3;
  localparam int OP_BRCOND = 4;
  localparam int OP_CALL   = 5;
  localparam int OP_RETURN = 6;
  localparam int OP_JUMP   = 7;

  typedef struct packed {
    logic alu;
    logic load;
    logic store;
    logic branch;
    logic brcond;
    logic call;
    logic ret;
    logic jump;
  } iclass_t;

  // Final step used by an instruction class
  function automatic step_e final_step(iclass_t c);
    if (c.alu || c.load || c.call) return ST_WBACK;
    else if (c.store)              return ST_MEM;
    else                           return ST_EXEC;
  endfunction

endpackage

// File: rtl/ctl_ir_decode.sv
module ctl_ir_decode
  import ctl_step_pkg::*;
#(
  parameter int IW      = 32,
  parameter int OPC_LSB = 0,
  parameter int OPC_W   = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ir_load,
  input  logic [IW-1:0] instr_in,
  output logic [IW-1:0] ir_q,
  output iclass_t       cls
);

  localparam int OPC_MSB = OPC_LSB + OPC_W - 1;

  logic [IW-1:0]    ir_d;
  logic [OPC_W-1:0] opcode;

  // Next-state: load on fetch completion, otherwise hold
  always_comb begin
    ir_d = ir_q;
    if (ir_load) ir_d = instr_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ir_q <= '0;
    else        ir_q <= ir_d;
  end

  assign opcode = ir_q[OPC_MSB:OPC_LSB];

  // Class flags from the held word only
  always_comb begin
    cls = '0;
    case (int'(opcode))
      OP_ALU:    cls.alu    = 1'b1;
      OP_LOAD:   cls.load   = 1'b1;
      OP_STORE:  cls.store  = 1'b1;
      OP_BRANCH: cls.branch = 1'b1;
      OP_BRCOND: cls.brcond = 1'b1;
      OP_CALL:   cls.call   = 1'b1;
      OP_RETURN: cls.ret    = 1'b1;
      OP_JUMP:   cls.jump   = 1'b1;
      default:   cls        = '0;
    endcase
  end

endmodule

// File: rtl/ctl_step_counter.sv
module ctl_step_counter
  import ctl_step_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 mfc,
  input  iclass_t              cls,
  output step_e                step_q,
  output logic                 run_q,
  output logic [NUM_STEPS-1:0] step_oh
);

  step_e step_d;
  step_e last_step;
  logic  mem_stall_cls;

  assign last_step     = final_step(cls);
  assign mem_stall_cls = cls.load | cls.store;

  always_comb begin
    step_d = step_q;
    if (!run_q) begin
      step_d = ST_FETCH;
    end else begin
      case (step_q)
        ST_FETCH:  if (mfc) step_d = ST_DECODE;
        ST_DECODE: step_d = ST_EXEC;
        ST_EXEC:   step_d = (last_step == ST_EXEC) ? ST_FETCH : ST_MEM;
        ST_MEM: begin
          if (mem_stall_cls && !mfc)    step_d = ST_MEM;
          else if (last_step == ST_MEM) step_d = ST_FETCH;
          else                          step_d = ST_WBACK;
        end
        ST_WBACK:  step_d = ST_FETCH;
        default:   step_d = ST_FETCH;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= ST_FETCH;
      run_q  <= 1'b0;
    end else begin
      step_q <= step_d;
      run_q  <= 1'b1;
    end
  end

  for (genvar g = 0; g < NUM_STEPS; g++) begin : g_oh
    assign step_oh[g] = (int'(step_q) == g);
  end

endmodule

// File: rtl/ctl_enable_gen.sv
module ctl_enable_gen
  import ctl_step_pkg::*;
(
  input  step_e   step_q,
  input  logic    run_q,
  input  logic    mfc,
  input  logic    cond_true,
  input  iclass_t cls,
  output logic    ir_en,
  output logic    pc_en,
  output logic    rf_we,
  output logic    mem_rd,
  output logic    mem_wr
);

  logic in_fetch, in_exec, in_mem, in_wback;
  logic taken, writes_reg;

  always_comb begin
    in_fetch   = run_q && (step_q == ST_FETCH);
    in_exec    = run_q && (step_q == ST_EXEC);
    in_mem     = run_q && (step_q == ST_MEM);
    in_wback   = run_q && (step_q == ST_WBACK);
    taken      = cls.branch | cls.call | cls.ret | cls.jump | (cls.brcond & cond_true);
    writes_reg = cls.alu | cls.load | cls.call;

    mem_rd = in_fetch | (in_mem & cls.load);
    mem_wr = in_mem & cls.store;
    ir_en  = in_fetch & mfc;
    pc_en  = (in_fetch & mfc) | (in_exec & taken);
    rf_we  = in_wback & writes_reg;
  end

endmodule

// File: rtl/ctl_step_seq.sv
module ctl_step_seq
  import ctl_step_pkg::*;
#(
  parameter int IW      = 32,
  parameter int OPC_LSB = 0,
  parameter int OPC_W   = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 mfc,
  input  logic                 cond_true,
  input  logic [IW-1:0]        instr_in,
  output logic [NUM_STEPS-1:0] step_oh,
  output logic [IW-1:0]        ir_hold,
  output logic                 ir_en,
  output logic                 pc_en,
  output logic                 rf_we,
  output logic                 mem_rd,
  output logic                 mem_wr
);

  step_e   step_q;
  logic    run_q;
  iclass_t cls;

  ctl_ir_decode #(
    .IW(IW), .OPC_LSB(OPC_LSB), .OPC_W(OPC_W)
  ) u_ir (
    .clk(clk), .rst_n(rst_n), .ir_load(ir_en),
    .instr_in(instr_in), .ir_q(ir_hold), .cls(cls)
  );

  ctl_step_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .mfc(mfc), .cls(cls),
    .step_q(step_q), .run_q(run_q), .step_oh(step_oh)
  );

  ctl_enable_gen u_en (
    .step_q(step_q), .run_q(run_q), .mfc(mfc), .cond_true(cond_true),
    .cls(cls), .ir_en(ir_en), .pc_en(pc_en), .rf_we(rf_we),
    .mem_rd(mem_rd), .mem_wr(mem_wr)
  );

endmodule

// File: rtl/ctl_step_seq_chk.sv
module ctl_step_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       mfc,
  input logic [4:0] step_oh,
  input logic       ir_en,
  input logic       pc_en,
  input logic       rf_we,
  input logic       mem_rd,
  input logic       mem_wr
);

  AST_STEP_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(step_oh) == 1); // R1

  AST_DECODE_ADV: assert property (@(posedge clk) disable iff (!rst_n)
    step_oh[1] |=> step_oh[2]); // R1

  AST_FETCH_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    step_oh[0] && !mfc |=> step_oh[0]); // R2

  AST_MEM_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    step_oh[3] && (mem_rd || mem_wr) && !mfc |=> step_oh[3]); // R3

  AST_MEM_NOWAIT: assert property (@(posedge clk) disable iff (!rst_n)
    step_oh[3] && !mem_rd && !mem_wr |=> !step_oh[3]); // R3

  AST_WBACK_RET: assert property (@(posedge clk) disable iff (!rst_n)
    step_oh[4] |=> step_oh[0]); // R4

  AST_FETCH_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    step_oh[0] && mem_rd && mfc |=> !mem_rd); // R5

  AST_NO_RDWR: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr)); // R5

  AST_IR_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    ir_en |=> step_oh[1]); // R6

  AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    pc_en |-> step_oh[0] || step_oh[2]); // R7

  AST_RF_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> step_oh[4]); // R8

endmodule

bind ctl_step_seq ctl_step_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mfc(mfc), .step_oh(step_oh),
  .ir_en(ir_en), .pc_en(pc_en), .rf_we(rf_we),
  .mem_rd(mem_rd), .mem_wr(mem_wr)
);

// File: tb/ctl_step_seq_bench.sv
module ctl_step_seq_bench;

  localparam int CLK_P  = 10;
  localparam int IW     = 32;
  localparam int NCYC   = 4000;
  localparam int NDIR   = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          mfc = 1'b0;
  logic          cond_true = 1'b0;
  logic [IW-1:0] instr_in = '0;
  logic [4:0]    step_oh;
  logic [IW-1:0] ir_hold;
  logic          ir_en, pc_en, rf_we, mem_rd, mem_wr;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  ctl_step_seq #(.IW(IW)) u_ctl_step_seq (
    .clk(clk), .rst_n(rst_n), .mfc(mfc), .cond_true(cond_true),
    .instr_in(instr_in), .step_oh(step_oh), .ir_hold(ir_hold),
    .ir_en(ir_en), .pc_en(pc_en), .rf_we(rf_we),
    .mem_rd(mem_rd), .mem_wr(mem_wr)
  );

  // Reference model state (steps numbered 1..5)
  int            m_step;
  bit            m_run;
  logic [IW-1:0] m_ir;

  function automatic int last_of(logic [IW-1:0] w);
    int op = int'(w[5:0]);
    if (op == 0 || op == 1 || op == 5) return 5;
    if (op == 2) return 4;
    return 3;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_step = 1; m_run = 1'b0; m_ir = '0;
    end else if (!m_run) begin
      m_run = 1'b1;
    end else begin
      case (m_step)
        1: if (mfc) begin m_ir = instr_in; m_step = 2; end
        2: m_step = 3;
        3: m_step = (last_of(m_ir) == 3) ? 1 : 4;
        4: begin
          if ((m_ir[5:0] == 6'd1 || m_ir[5:0] == 6'd2) && !mfc) m_step = 4;
          else m_step = (last_of(m_ir) == 4) ? 1 : 5;
        end
        default: m_step = 1;
      endcase
    end
  end

  task automatic chk(string tag, logic [IW-1:0] act, logic [IW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h step=%0d t=%0t", tag, act, exp, m_step, $time);
    end
  endtask

  logic [15:0] lfsr = 16'hACE1;
  task automatic lfsr_step();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  int dir_op [NDIR];
  int dir_lat[NDIR];
  int di = 0;
  bit busy = 1'b0;
  int cnt = 0;

  function automatic int pick_lat();
    int l;
    if (di < NDIR) l = dir_lat[di];
    else l = int'(lfsr[1:0]) + ((lfsr[7:4] == 4'd0) ? 5 : 0);
    return l;
  endfunction

  initial begin
    dir_op  = '{0, 1, 2, 3, 4, 4, 5, 6, 7, 12, 1, 2, 0, 63, 5, 4};
    dir_lat = '{0, 1, 3, 0, 2, 0, 5, 1, 0, 4, 0, 6, 2, 1, 0, 3};
  end

  initial begin
    int op;
    logic e_rd, e_wr, e_ire, e_pc, e_rf, taken, req;
    string tg;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int cyc = 0; cyc < NCYC; cyc++) begin
      @(negedge clk);
      lfsr_step();
      if (cyc == 2000) rst_n = 1'b0;
      if (cyc == 2003) rst_n = 1'b1;
      req = mem_rd | mem_wr;
      cond_true = lfsr[9];
      instr_in  = {lfsr, lfsr};
      if (!rst_n) begin
        busy = 1'b0; mfc = lfsr[2];
      end else if (req) begin
        if (!busy) begin busy = 1'b1; cnt = pick_lat(); end
        if (cnt == 0) begin
          mfc = 1'b1; busy = 1'b0;
          if (step_oh[0]) begin
            op = (di < NDIR) ? dir_op[di] : int'(lfsr[3:0] % 4'd10);
            instr_in = {lfsr, 10'h2A5, 6'(op)};
            if (di < NDIR) di++;
          end
        end else begin
          cnt--; mfc = 1'b0;
        end
      end else begin
        mfc = lfsr[3] & lfsr[5];   // stray completion pulses
      end
      #1;
      op    = int'(m_ir[5:0]);
      taken = (op == 3 || op == 5 || op == 6 || op == 7 || (op == 4 && cond_true));
      e_rd  = m_run && (m_step == 1 || (m_step == 4 && op == 1));
      e_wr  = m_run && m_step == 4 && op == 2;
      e_ire = m_run && m_step == 1 && mfc;
      e_pc  = m_run && ((m_step == 1 && mfc) || (m_step == 3 && taken));
      e_rf  = m_run && m_step == 5 && (op == 0 || op == 1 || op == 5);
      if (!m_run) tg = "R9 ";
      else tg = "";
      chk({tg, "R1/R2/R3/R4 step"}, IW'(step_oh), IW'(1 << (m_step - 1)));
      chk({tg, "R5 mem_rd"}, IW'(mem_rd), IW'(e_rd));
      chk({tg, "R5 mem_wr"}, IW'(mem_wr), IW'(e_wr));
      chk({tg, "R6 ir_en"}, IW'(ir_en), IW'(e_ire));
      chk({tg, "R6 ir_hold"}, ir_hold, m_ir);
      chk({tg, "R7 pc_en"}, IW'(pc_en), IW'(e_pc));
      chk({tg, "R8 rf_we"}, IW'(rf_we), IW'(e_rf));
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule